// File: doc/BRIEF.md
# Packet Launch Latency Scheduler

This block sits between a pattern engine and a packet serializer in a memory tester. The pattern engine presents at most one transaction request per packet cycle. One packet cycle is four pin clocks, which is eight launch edges. For every request the block schedules three launches: a row packet, a column packet and a data packet. Each launch is held in its own lane queue until it is due. In the packet cycle it is due, the lane raises its strobe together with the edge offset (0 to 7) at which the serializer must start the packet.

Every launch time is kept in edge units. Its packet cycle is the edge count divided by eight, and its edge offset is the remainder. Three delays are loaded once after device initialisation and are then left alone for the run:

- the row-to-column delay;
- the column-to-data delay for writes;
- the column-to-data delay for reads.

A turnaround bubble of n pin clocks, which is 2n edges, is added to a whole transaction when its direction differs from the direction of the previous request. This spaces the read-to-write and write-to-read turns of interleaved read-read-write-write traffic.

Top module: `pls_sched`

## Requirements
- R1: While reset is asserted and after its release, every lane strobe is low, `idle` is high and both error flags are low. Reset discards all pending launches.
- R2: A request sampled at the clock edge that ends cycle t gets a row launch time of 8*(t+1)+B edges. B is the bubble (see R5) and is otherwise 0. The row lane is lane index 0.
- R3: The column launch time is the row launch time plus `cfg_row2col` edges. The column lane is lane index 1.
- R4: The data launch time is the column launch time plus `cfg_col2wr` when `req_write`=1, or plus `cfg_col2rd` when `req_write`=0. The data lane is lane index 2.
- R5: B equals 2*`cfg_bubble` when the request's direction differs from that of the previous request since reset. It is 0 for the first request after reset and whenever the direction is unchanged.
- R6: A launch with time E strobes its lane in the cycle where the cycle count equals floor(E/8). That lane's `lane_fine` then equals E mod 8, and its `lane_tag` and `lane_write` carry the request's tag and direction.
- R7: Suppose a new launch time is earlier than eight edges after the last launch accepted on the same lane. That launch is dropped and `err_overlap` is set. The flag stays set until reset.
- R8: Suppose a lane already holds QDEPTH launches that are not due in the current cycle. A further launch on that lane is dropped and `err_full` is set until reset. The overlap test takes precedence over this one.
- R9: A configuration write takes effect only when `cfg_we`=1, `idle`=1 and `req_valid`=0 in the same cycle. In every other case it is ignored.
- R10: `idle` is high exactly when no lane holds a pending launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Packet-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Delay register write request |
| cfg_row2col | input | LAT_W | Row-to-column delay, in edges |
| cfg_col2wr | input | LAT_W | Column-to-data delay for writes, in edges |
| cfg_col2rd | input | LAT_W | Column-to-data delay for reads, in edges |
| cfg_bubble | input | BUB_W | Turnaround bubble, in pin clocks |
| req_valid | input | 1 | Transaction request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Payload tag forwarded with each launch |
| lane_fire | output | 3 | Launch strobe per lane (0 row, 1 column, 2 data) |
| lane_fine | output | 3x3 | Start edge within the packet cycle, per lane |
| lane_tag | output | 3xTAG_W | Tag of the launching packet, per lane |
| lane_write | output | 3 | Direction of the launching packet, per lane |
| idle | output | 1 | No launch pending in any lane |
| err_overlap | output | 1 | Sticky: a launch was dropped for colliding with its lane |
| err_full | output | 1 | Sticky: a launch was dropped because its lane queue was full |

## Verification
The bench builds the block with a 6-bit cycle counter and a queue depth of 4. The short counter makes the launch-time arithmetic wrap every 64 packet cycles, so the wrap-safe due comparison and the signed collision test are exercised many times in one run. With the shallow queue, a row-to-column delay near its 63-edge maximum fills the column lane after a few back-to-back requests, which brings the drop-on-full path within reach. Directed traffic covers turnaround bubbles and reads whose data would land after a following write. Random delay sets then mix short, long and offset-crossing latencies.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int NLANE     = 3;
    localparam int FINE_W    = 3;
    localparam int EDGES_CYC = 8;

    typedef enum logic [1:0] {
        LANE_ROW = 2'd0,
        LANE_COL = 2'd1,
        LANE_DAT = 2'd2
    } lane_e;
endpackage

// File: rtl/pls_due_calc.sv
module pls_due_calc #(
    parameter int LAT_W = 6,
    parameter int BUB_W = 3,
    parameter int CYC_W = 10,
    parameter int EW    = CYC_W + 3
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic             turn,
    input  logic             is_write,
    input  logic [LAT_W-1:0] r2c,
    input  logic [LAT_W-1:0] c2w,
    input  logic [LAT_W-1:0] c2r,
    input  logic [BUB_W-1:0] bub,
    output logic [EW-1:0]    due_row,
    output logic [EW-1:0]    due_col,
    output logic [EW-1:0]    due_dat
);
    logic [CYC_W-1:0] nxt_cyc;
    logic [EW-1:0]    base;
    logic [EW-1:0]    skew;
    logic [LAT_W-1:0] dat_lat;

    always_comb begin
        nxt_cyc = cyc + CYC_W'(1);
        base    = {nxt_cyc, 3'b000};
        skew    = turn ? EW'({bub, 1'b0}) : '0;
        dat_lat = is_write ? c2w : c2r;
        due_row = base + skew;
        due_col = due_row + EW'(r2c);
        due_dat = due_col + EW'(dat_lat);
    end
endmodule

// File: rtl/pls_lane_queue.sv
module pls_lane_queue #(
    parameter int DEPTH = 4,
    parameter int CYC_W = 10,
    parameter int PW    = 9,
    parameter int EW    = CYC_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cyc,
    input  logic             push,
    input  logic [EW-1:0]    push_due,
    input  logic [PW-1:0]    push_pl,
    output logic             fire,
    output logic [2:0]       fire_fine,
    output logic [PW-1:0]    fire_pl,
    output logic             drop_overlap,
    output logic             drop_full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic signed [EW-1:0] PKT_EDGES = EW'(8);

    typedef struct packed {
        logic [EW-1:0] due;
        logic [PW-1:0] pl;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic [EW-1:0]    last;
        logic             lastv;
    } st_t;

    st_t st_q, st_d;
    ent_t head;
    logic [EW-1:0]    diff;
    logic [CYC_W-1:0] age;
    logic busy, full, do_push;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        head      = st_q.mem[st_q.rd];
        fire      = (st_q.cnt != '0) && (head.due[EW-1:3] == cyc);
        fire_fine = head.due[2:0];
        fire_pl   = head.pl;
        diff      = push_due - st_q.last;
        busy      = st_q.lastv && ($signed(diff) < PKT_EDGES);
        full      = (st_q.cnt == CNT_W'(DEPTH)) && !fire;
        drop_overlap = push && busy;
        drop_full    = push && !busy && full;
        do_push      = push && !busy && !full;
        age       = cyc - st_q.last[EW-1:3];
        empty     = (st_q.cnt == '0);

        if (fire) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        if (do_push) begin
            st_d.mem[st_q.wr] = '{due: push_due, pl: push_pl};
            st_d.wr           = ptr_inc(st_q.wr);
            st_d.last         = push_due;
            st_d.lastv        = 1'b1;
        end else if (empty && (age >= CYC_W'(2))) begin
            st_d.lastv = 1'b0;
        end
        case ({do_push, fire})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pls_sched.sv
module pls_sched
    import pls_pkg::*;
#(
    parameter int LAT_W  = 6,
    parameter int BUB_W  = 3,
    parameter int TAG_W  = 8,
    parameter int QDEPTH = 4,
    parameter int CYC_W  = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [LAT_W-1:0]                  cfg_row2col,
    input  logic [LAT_W-1:0]                  cfg_col2wr,
    input  logic [LAT_W-1:0]                  cfg_col2rd,
    input  logic [BUB_W-1:0]                  cfg_bubble,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [TAG_W-1:0]                  req_tag,
    output logic [NLANE-1:0]                  lane_fire,
    output logic [NLANE-1:0][FINE_W-1:0]      lane_fine,
    output logic [NLANE-1:0][TAG_W-1:0]       lane_tag,
    output logic [NLANE-1:0]                  lane_write,
    output logic                              idle,
    output logic                              err_overlap,
    output logic                              err_full
);
    localparam int EW   = CYC_W + 3;
    localparam int PW   = TAG_W + 1;
    localparam int CFGW = 3 * LAT_W + BUB_W;

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [LAT_W-1:0] r2c;
        logic [LAT_W-1:0] c2w;
        logic [LAT_W-1:0] c2r;
        logic [BUB_W-1:0] bub;
        logic             prev_vld;
        logic             prev_w;
        logic             ovl;
        logic             full;
    } st_t;

    st_t st_q, st_d;

    logic                         turn;
    logic                         cfg_ok;
    logic [EW-1:0]                due_row, due_col, due_dat;
    logic [NLANE-1:0][EW-1:0]     due_v;
    logic [NLANE-1:0][PW-1:0]     pl_v;
    logic [NLANE-1:0]             drop_ovl_v, drop_full_v, empty_v;
    logic [CFGW-1:0]              cfg_vec;

    assign turn    = req_valid && st_q.prev_vld && (st_q.prev_w != req_write);
    assign due_v   = {due_dat, due_col, due_row};
    assign idle    = &empty_v;
    assign cfg_ok  = cfg_we && idle && !req_valid;
    assign cfg_vec = {st_q.r2c, st_q.c2w, st_q.c2r, st_q.bub};

    pls_due_calc #(
        .LAT_W(LAT_W), .BUB_W(BUB_W), .CYC_W(CYC_W), .EW(EW)
    ) u_due (
        .cyc      (st_q.cyc),
        .turn     (turn),
        .is_write (req_write),
        .r2c      (st_q.r2c),
        .c2w      (st_q.c2w),
        .c2r      (st_q.c2r),
        .bub      (st_q.bub),
        .due_row  (due_row),
        .due_col  (due_col),
        .due_dat  (due_dat)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        pls_lane_queue #(
            .DEPTH(QDEPTH), .CYC_W(CYC_W), .PW(PW), .EW(EW)
        ) u_q (
            .clk          (clk),
            .rst_n        (rst_n),
            .cyc          (st_q.cyc),
            .push         (req_valid),
            .push_due     (due_v[g]),
            .push_pl      ({req_write, req_tag}),
            .fire         (lane_fire[g]),
            .fire_fine    (lane_fine[g]),
            .fire_pl      (pl_v[g]),
            .drop_overlap (drop_ovl_v[g]),
            .drop_full    (drop_full_v[g]),
            .empty        (empty_v[g])
        );
        assign lane_write[g] = pl_v[g][PW-1];
        assign lane_tag[g]   = pl_v[g][TAG_W-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + CYC_W'(1);
        if (cfg_ok) begin
            st_d.r2c = cfg_row2col;
            st_d.c2w = cfg_col2wr;
            st_d.c2r = cfg_col2rd;
            st_d.bub = cfg_bubble;
        end
        if (req_valid) begin
            st_d.prev_vld = 1'b1;
            st_d.prev_w   = req_write;
        end
        if (|drop_ovl_v)  st_d.ovl  = 1'b1;
        if (|drop_full_v) st_d.full = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_overlap = st_q.ovl;
    assign err_full    = st_q.full;
endmodule

// File: rtl/pls_sched_chk.sv
module pls_sched_chk #(
    parameter int NLANE = 3,
    parameter int TAG_W = 8,
    parameter int CFGW  = 21,
    parameter int BUB_W = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_we,
    input logic                         req_valid,
    input logic [TAG_W-1:0]             req_tag,
    input logic [NLANE-1:0]             lane_fire,
    input logic [NLANE-1:0][2:0]        lane_fine,
    input logic [NLANE-1:0][TAG_W-1:0]  lane_tag,
    input logic                         idle,
    input logic                         err_overlap,
    input logic                         err_full,
    input logic [CFGW-1:0]              cfg_vec
);
    logic bub_zero;
    assign bub_zero = (cfg_vec[BUB_W-1:0] == '0);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (lane_fire == '0 && idle)); // R1

    AST_ROW_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle && bub_zero) |=> (lane_fire[0] && lane_fine[0] == 3'd0 && lane_tag[0] == $past(req_tag))); // R2

    AST_OVL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_overlap |=> err_overlap); // R7

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_full |=> err_full); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && idle && !req_valid) |=> $stable(cfg_vec)); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) idle |-> (lane_fire == '0)); // R10
endmodule

bind pls_sched pls_sched_chk #(
    .NLANE(NLANE), .TAG_W(TAG_W), .CFGW(CFGW), .BUB_W(BUB_W)
) u_chk (.*);

// File: tb/pls_sched_tb.sv
module pls_sched_tb;
    localparam int LAT_W  = 6;
    localparam int BUB_W  = 3;
    localparam int TAG_W  = 8;
    localparam int QDEPTH = 4;
    localparam int CYC_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [LAT_W-1:0] cfg_row2col = '0, cfg_col2wr = '0, cfg_col2rd = '0;
    logic [BUB_W-1:0] cfg_bubble = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [2:0] lane_fire, lane_write;
    logic [2:0][2:0] lane_fine;
    logic [2:0][TAG_W-1:0] lane_tag;
    logic idle, err_overlap, err_full;

    pls_sched #(.LAT_W(LAT_W), .BUB_W(BUB_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH), .CYC_W(CYC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row2col(cfg_row2col),
        .cfg_col2wr(cfg_col2wr), .cfg_col2rd(cfg_col2rd), .cfg_bubble(cfg_bubble),
        .req_valid(req_valid), .req_write(req_write), .req_tag(req_tag),
        .lane_fire(lane_fire), .lane_fine(lane_fine), .lane_tag(lane_tag),
        .lane_write(lane_write), .idle(idle), .err_overlap(err_overlap), .err_full(err_full)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int bcyc = 0;
    int mdue[3][256];
    int mtag[3][256];
    bit mwr[3][256];
    bit mbub[3][256];
    int mrd[3], mwi[3], mlast[3];
    bit mlastv[3];
    int m_r2c, m_c2w, m_c2r, m_bub;
    bit m_prevv, m_prevw, m_ovl, m_full, idle_exp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, bcyc);
        end
    endtask

    task automatic model_clear();
        for (int l = 0; l < 3; l++) begin
            mrd[l] = 0; mwi[l] = 0; mlast[l] = 0; mlastv[l] = 1'b0;
        end
        m_r2c = 0; m_c2w = 0; m_c2r = 0; m_bub = 0;
        m_prevv = 0; m_prevw = 0; m_ovl = 0; m_full = 0; bcyc = 0;
    endtask

    task automatic check_cycle();
        idle_exp = 1'b1;
        for (int l = 0; l < 3; l++) if (mrd[l] != mwi[l]) idle_exp = 1'b0;
        for (int l = 0; l < 3; l++) begin
            automatic int h = mrd[l] % 256;
            automatic bit ef = (mrd[l] != mwi[l]) && (mdue[l][h] / 8 == bcyc);
            automatic string r = (l == 0) ? (mbub[l][h] ? "R5" : "R2") : ((l == 1) ? "R3" : "R4");
            chk(lane_fire[l] == ef, {r, " strobe"}, int'(lane_fire[l]), int'(ef));
            if (ef) begin
                chk(int'(lane_fine[l]) == mdue[l][h] % 8, {r, " fine offset"}, int'(lane_fine[l]), mdue[l][h] % 8);
                chk(int'(lane_tag[l]) == mtag[l][h], "R6 tag", int'(lane_tag[l]), mtag[l][h]);
                chk(lane_write[l] == mwr[l][h], "R6 direction", int'(lane_write[l]), int'(mwr[l][h]));
                mrd[l]++;
            end
        end
        chk(idle == idle_exp, "R10 idle", int'(idle), int'(idle_exp));
        chk(err_overlap == m_ovl, "R7 err_overlap", int'(err_overlap), int'(m_ovl));
        chk(err_full == m_full, "R8 err_full", int'(err_full), int'(m_full));
    endtask

    task automatic model_edge(input bit v, input bit w, input int tag, input bit cwe,
                              input int r2c, input int c2w, input int c2r, input int bub);
        int due[3];
        bit bb;
        if (cwe && idle_exp && !v) begin
            m_r2c = r2c; m_c2w = c2w; m_c2r = c2r; m_bub = bub;
        end
        if (v) begin
            bb = m_prevv && (m_prevw != w);
            due[0] = 8 * (bcyc + 1) + (bb ? 2 * m_bub : 0);
            due[1] = due[0] + m_r2c;
            due[2] = due[1] + (w ? m_c2w : m_c2r);
            for (int l = 0; l < 3; l++) begin
                if (mlastv[l] && due[l] < mlast[l] + 8) m_ovl = 1'b1;
                else if (mwi[l] - mrd[l] == QDEPTH) m_full = 1'b1;
                else begin
                    mdue[l][mwi[l] % 256] = due[l];
                    mtag[l][mwi[l] % 256] = tag;
                    mwr[l][mwi[l] % 256]  = w;
                    mbub[l][mwi[l] % 256] = bb;
                    mwi[l]++;
                    mlast[l] = due[l];
                    mlastv[l] = 1'b1;
                end
            end
            m_prevv = 1'b1; m_prevw = w;
        end
    endtask

    task automatic step(input bit v, input bit w, input int tag, input bit cwe,
                        input int r2c, input int c2w, input int c2r, input int bub);
        check_cycle();
        req_valid = v; req_write = w; req_tag = TAG_W'(tag); cfg_we = cwe;
        cfg_row2col = LAT_W'(r2c); cfg_col2wr = LAT_W'(c2w); cfg_col2rd = LAT_W'(c2r);
        cfg_bubble = BUB_W'(bub);
        @(posedge clk);
        model_edge(v, w, tag, cwe, r2c, c2w, c2r, bub);
        bcyc++;
        @(negedge clk);
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic cfg(input int r2c, input int c2w, input int c2r, input int bub);
        step(0, 0, 0, 1, r2c, c2w, c2r, bub);
    endtask

    task automatic req(input bit w, input int tag);
        step(1, w, tag, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 0; cfg_we = 0;
        model_clear();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(lane_fire == 3'b000, "R1 strobes in reset", int'(lane_fire), 0);
            chk(idle && !err_overlap && !err_full, "R1 idle/errors in reset",
                int'({idle, err_overlap, err_full}), 4);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        do_reset();
        // R1: quiet after release
        idle_n(2);
        // R2 R3 R4 basic read, then turnaround write (R5), then plain write
        cfg(11, 9, 21, 1);
        req(0, 8'h11); idle_n(8);
        req(1, 8'h22); idle_n(8);
        req(1, 8'h23); idle_n(8);
        req(0, 8'h24); idle_n(8);
        // R9: write while busy and write alongside a request are ignored
        req(0, 8'h31);
        cfg(40, 40, 40, 7);
        idle_n(10);
        step(1, 0, 8'h32, 1, 5, 5, 5, 0);
        idle_n(10);
        req(0, 8'h33); idle_n(10);
        // R7: read data lands after following write's data
        cfg(0, 0, 40, 0);
        req(0, 8'h41); req(1, 8'h42); idle_n(12);
        // R8: long row-to-column delay fills the column lane
        do_reset();
        cfg(63, 0, 0, 0);
        for (int i = 0; i < 8; i++) req(0, 8'h50 + i);
        idle_n(20);
        // random phase
        for (int blk = 0; blk < 40; blk++) begin
            if (blk % 10 == 0) do_reset();
            cfg(int'($urandom % 64), int'($urandom % 64), int'($urandom % 64), int'($urandom % 8));
            for (int i = 0; i < 50; i++) begin
                if ($urandom % 3 == 0) req(bit'($urandom % 2), int'($urandom % 256));
                else idle_n(1);
            end
            idle_n(25);
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule